// File: doc/BRIEF.md
# Load-Effective-Address Decode and Address Unit

This block takes one 64-bit-mode load-effective-address instruction (opcode byte 0x8D) from a buffer of up to fifteen bytes. It walks through it one byte per clock, reads the registers it needs from a 16-entry 64-bit register file, and produces the value to be written to the destination register. It handles the operand-size and address-size prefixes in either order, the REX prefix, ModRM, SIB, 8-bit and 32-bit displacements, the SIB codes for no base and no index, and instruction-pointer-relative addressing.

A caller places the bytes and the instruction's own address on the inputs and pulses `start`. Some cycles later `done` is high for one cycle. In that cycle `dst_idx`, `wr_data` and `insn_len` carry the result. The caller writes `wr_data` into register `dst_idx` only when `done` is high and `invalid` is low. The register file is read through a single asynchronous read port that the block addresses one register per cycle.

Top module: `lea_unit`

## Requirements
- R1: When REX.W is set (a REX byte of 0x48 to 0x4F), `wr_data` is the full 64-bit effective address, whether or not 0x66 is present.
- R2: Without REX.W and without 0x66, `wr_data` holds the low 32 bits of the address, and bits 63:32 are zero.
- R3: With 0x66 and without REX.W, `wr_data[15:0]` is the low 16 bits of the address, and `wr_data[63:16]` is the previous content of the destination register.
- R4: A 0x67 prefix clears bits 63:32 of the effective address before the operand-size rule is applied.
- R5: ModRM is mod[7:6], reg[5:3], rm[2:0]. REX bit 2 extends reg to form the 4-bit destination, and REX bit 0 extends rm. The address is the register plus a displacement: mod 1 adds one sign-extended byte, and mod 2 adds four little-endian bytes that are sign-extended.
- R6: An rm value with low bits 4 brings in a SIB byte: scale[7:6], index[5:3], base[2:0]. REX bit 1 extends index and REX bit 0 extends base. The index register is shifted left by the scale and added. Index code 4 means no index, while index 12 is an ordinary register.
- R7: With mod 0 and SIB base low bits 5 (base 5 or 13), no base register is used, and a 32-bit displacement follows the SIB byte.
- R8: Without SIB, mod 0 with rm low bits 5 means the address is `insn_addr` plus the instruction length plus the sign-extended 32-bit displacement.
- R9: The 0x66 and 0x67 prefixes may come in either order ahead of REX and give identical results.
- R10: `insn_len` counts the prefixes, REX, opcode, ModRM, the SIB byte if present, and the displacement bytes. A valid instruction is always at least 2 bytes long.
- R11: Two cases raise `invalid` together with `done` and leave `wr_data` and `dst_idx` unchanged: mod 3, and a byte other than 0x8D after the prefixes.
- R12: `done` lasts exactly one cycle. `wr_data`, `dst_idx` and `insn_len` change only in the cycle where `done` is high, and reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding the buffer (sampled while idle) |
| insn_bytes | input | 120 | Instruction bytes, byte 0 in bits 7:0 |
| insn_addr | input | 64 | Address of the first instruction byte |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 64 | Register file read data for `rf_raddr` |
| done | output | 1 | One-cycle completion strobe |
| invalid | output | 1 | Instruction rejected (with `done`) |
| dst_idx | output | 4 | Destination register index |
| wr_data | output | 64 | Value for the destination register |
| insn_len | output | 4 | Decoded instruction length in bytes |

## Verification
If the byte pointer is off by one, every later field is read from the wrong byte. This shows up in the first finished instruction as a wrong `insn_len`, a spurious `invalid`, or a wrong displacement in `wr_data`. A latched prefix or REX bit that is stuck or not cleared between instructions damages the next instruction's size shaping or register choice, so the sweeps vary the prefixes and REX from one instruction to the next. A wrong register-read phase puts the wrong register's value into `wr_data`. The fixed, distinct register contents make this visible in the same `done` cycle.

// File: rtl/lea_pkg.sv
package lea_pkg;

    localparam int REG_W  = 4;
    localparam int ADDR_W = 64;
    localparam int DISP_W = 32;

    localparam logic [7:0] OPC_LEA  = 8'h8D;
    localparam logic [7:0] PFX_OPSZ = 8'h66;
    localparam logic [7:0] PFX_ADSZ = 8'h67;
    localparam logic [3:0] REX_HI   = 4'h4;

    typedef enum logic [1:0] {OSZ_16, OSZ_32, OSZ_64} opsize_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PFX, ST_OPC, ST_MODRM, ST_SIB,
        ST_DISP, ST_RBASE, ST_RIDX, ST_RDST
    } dec_state_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] reg_f;
        logic [2:0] rm;
    } modrm_t;

    typedef struct packed {
        logic [1:0] scale;
        logic [2:0] index;
        logic [2:0] base;
    } sib_t;

    typedef struct packed {
        logic w;
        logic r;
        logic x;
        logic b;
    } rex_t;

    typedef struct packed {
        opsize_e           osz;
        logic              adr32;
        logic              rip;
        logic              use_base;
        logic              use_index;
        logic [1:0]        scale;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  base;
        logic [REG_W-1:0]  index;
        logic [DISP_W-1:0] disp;
    } lea_ctl_t;

    // Number of displacement bytes implied by mod and the base/rm low bits.
    function automatic logic [2:0] disp_bytes(logic [1:0] mode, logic [2:0] low);
        if (mode == 2'd1)                       return 3'd1;
        else if (mode == 2'd2)                  return 3'd4;
        else if (mode == 2'd0 && low == 3'd5)   return 3'd4;
        else                                    return 3'd0;
    endfunction

    function automatic logic [ADDR_W-1:0] size_result(opsize_e osz,
                                                      logic [ADDR_W-1:0] ea,
                                                      logic [ADDR_W-1:0] prior);
        case (osz)
            OSZ_64:  return ea;
            OSZ_16:  return {prior[ADDR_W-1:16], ea[15:0]};
            default: return {{(ADDR_W-32){1'b0}}, ea[31:0]};
        endcase
    endfunction

endpackage

// File: rtl/lea_decoder.sv
module lea_decoder
    import lea_pkg::*;
#(
    parameter int NBYTES = 15,
    localparam int POS_W = $clog2(NBYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NBYTES*8-1:0]   insn_bytes,
    output logic [REG_W-1:0]      rf_raddr,
    input  logic [ADDR_W-1:0]     rf_rdata,
    output lea_ctl_t              ctl,
    output logic [ADDR_W-1:0]     base_val,
    output logic [ADDR_W-1:0]     idx_val,
    output logic [POS_W-1:0]      len,
    output logic                  fin_ok,
    output logic                  fin_bad
);

    dec_state_e            st_q;
    logic [NBYTES*8-1:0]   buf_q;
    logic [POS_W-1:0]      pos_q;
    logic [2:0]            dcnt_q, dneed_q;
    logic                  p66_q, p67_q, has_sib_q;
    rex_t                  rex_q;
    modrm_t                modrm_q;
    sib_t                  sib_q;
    logic [DISP_W-1:0]     disp_q;
    logic [ADDR_W-1:0]     base_q, idx_q;

    logic [7:0] cur;
    modrm_t     cur_m;
    sib_t       cur_s;
    logic [2:0] need_m, need_s;

    assign cur    = (pos_q < POS_W'(NBYTES)) ? buf_q[8*pos_q +: 8] : 8'h00;
    assign cur_m  = modrm_t'(cur);
    assign cur_s  = sib_t'(cur);
    assign need_m = disp_bytes(cur_m.mode, cur_m.rm);
    assign need_s = disp_bytes(modrm_q.mode, cur_s.base);

    always_comb begin
        ctl.osz       = rex_q.w ? OSZ_64 : (p66_q ? OSZ_16 : OSZ_32);
        ctl.adr32     = p67_q;
        ctl.rip       = !has_sib_q && modrm_q.mode == 2'd0 && modrm_q.rm == 3'd5;
        ctl.dst       = {rex_q.r, modrm_q.reg_f};
        ctl.base      = has_sib_q ? {rex_q.b, sib_q.base} : {rex_q.b, modrm_q.rm};
        ctl.use_base  = has_sib_q ? !(modrm_q.mode == 2'd0 && sib_q.base == 3'd5)
                                  : !ctl.rip;
        ctl.index     = {rex_q.x, sib_q.index};
        ctl.use_index = has_sib_q && ({rex_q.x, sib_q.index} != 4'd4);
        ctl.scale     = sib_q.scale;
        ctl.disp      = disp_q;
    end

    always_comb begin
        case (st_q)
            ST_RBASE: rf_raddr = ctl.base;
            ST_RIDX:  rf_raddr = ctl.index;
            default:  rf_raddr = ctl.dst;
        endcase
    end

    assign fin_ok   = (st_q == ST_RDST);
    assign fin_bad  = (st_q == ST_OPC && cur != OPC_LEA) ||
                      (st_q == ST_MODRM && cur_m.mode == 2'd3);
    assign base_val = base_q;
    assign idx_val  = idx_q;
    assign len      = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            buf_q     <= '0;
            pos_q     <= '0;
            dcnt_q    <= '0;
            dneed_q   <= '0;
            p66_q     <= 1'b0;
            p67_q     <= 1'b0;
            has_sib_q <= 1'b0;
            rex_q     <= '0;
            modrm_q   <= '0;
            sib_q     <= '0;
            disp_q    <= '0;
            base_q    <= '0;
            idx_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    buf_q     <= insn_bytes;
                    pos_q     <= '0;
                    dcnt_q    <= '0;
                    dneed_q   <= '0;
                    p66_q     <= 1'b0;
                    p67_q     <= 1'b0;
                    has_sib_q <= 1'b0;
                    rex_q     <= '0;
                    modrm_q   <= '0;
                    sib_q     <= '0;
                    disp_q    <= '0;
                    st_q      <= ST_PFX;
                end
                ST_PFX: begin
                    if (pos_q == POS_W'(NBYTES - 1)) begin
                        st_q <= ST_OPC;
                    end else if (cur == PFX_OPSZ) begin
                        p66_q <= 1'b1;
                        pos_q <= pos_q + 1'b1;
                    end else if (cur == PFX_ADSZ) begin
                        p67_q <= 1'b1;
                        pos_q <= pos_q + 1'b1;
                    end else if (cur[7:4] == REX_HI) begin
                        rex_q <= rex_t'(cur[3:0]);
                        pos_q <= pos_q + 1'b1;
                        st_q  <= ST_OPC;
                    end else begin
                        st_q <= ST_OPC;
                    end
                end
                ST_OPC: begin
                    if (cur == OPC_LEA) begin
                        pos_q <= pos_q + 1'b1;
                        st_q  <= ST_MODRM;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_MODRM: begin
                    modrm_q <= cur_m;
                    if (cur_m.mode == 2'd3) begin
                        st_q <= ST_IDLE;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                        if (cur_m.rm == 3'd4) begin
                            st_q <= ST_SIB;
                        end else begin
                            dneed_q <= need_m;
                            st_q    <= (need_m != 3'd0) ? ST_DISP : ST_RBASE;
                        end
                    end
                end
                ST_SIB: begin
                    sib_q     <= cur_s;
                    has_sib_q <= 1'b1;
                    pos_q     <= pos_q + 1'b1;
                    dneed_q   <= need_s;
                    st_q      <= (need_s != 3'd0) ? ST_DISP : ST_RBASE;
                end
                ST_DISP: begin
                    if (dneed_q == 3'd1)
                        disp_q <= {{(DISP_W-8){cur[7]}}, cur};
                    else
                        disp_q[8*dcnt_q +: 8] <= cur;
                    pos_q  <= pos_q + 1'b1;
                    dcnt_q <= dcnt_q + 3'd1;
                    if (dcnt_q == dneed_q - 3'd1)
                        st_q <= ST_RBASE;
                end
                ST_RBASE: begin
                    base_q <= ctl.use_base ? rf_rdata : '0;
                    st_q   <= ST_RIDX;
                end
                ST_RIDX: begin
                    idx_q <= ctl.use_index ? rf_rdata : '0;
                    st_q  <= ST_RDST;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lea_agu.sv
module lea_agu
    import lea_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  lea_ctl_t           ctl,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  idx_val,
    input  logic [ADDR_W-1:0]  prior_val,
    input  logic [ADDR_W-1:0]  insn_addr,
    input  logic [LEN_W-1:0]   len,
    output logic [ADDR_W-1:0]  result
);

    logic [ADDR_W-1:0] base_term, scaled_idx, disp_ext, ea;

    always_comb begin
        base_term  = ctl.rip ? (insn_addr + ADDR_W'(len)) : base_val;
        scaled_idx = idx_val << ctl.scale;
        disp_ext   = {{(ADDR_W-DISP_W){ctl.disp[DISP_W-1]}}, ctl.disp};
        ea         = base_term + scaled_idx + disp_ext;
        if (ctl.adr32)
            ea[ADDR_W-1:32] = '0;
        result = size_result(ctl.osz, ea, prior_val);
    end

endmodule

// File: rtl/lea_unit.sv
module lea_unit
    import lea_pkg::*;
#(
    parameter int NBYTES = 15,
    localparam int LEN_W = $clog2(NBYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NBYTES*8-1:0]  insn_bytes,
    input  logic [63:0]          insn_addr,
    output logic [3:0]           rf_raddr,
    input  logic [63:0]          rf_rdata,
    output logic                 done,
    output logic                 invalid,
    output logic [3:0]           dst_idx,
    output logic [63:0]          wr_data,
    output logic [LEN_W-1:0]     insn_len
);

    lea_ctl_t          ctl;
    logic [63:0]       base_val, idx_val, result;
    logic [LEN_W-1:0]  len;
    logic              fin_ok, fin_bad;

    lea_decoder #(.NBYTES(NBYTES)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .insn_bytes (insn_bytes),
        .rf_raddr   (rf_raddr),
        .rf_rdata   (rf_rdata),
        .ctl        (ctl),
        .base_val   (base_val),
        .idx_val    (idx_val),
        .len        (len),
        .fin_ok     (fin_ok),
        .fin_bad    (fin_bad)
    );

    // In the final phase the read port addresses the destination register.
    lea_agu #(.LEN_W(LEN_W)) u_agu (
        .ctl       (ctl),
        .base_val  (base_val),
        .idx_val   (idx_val),
        .prior_val (rf_rdata),
        .insn_addr (insn_addr),
        .len       (len),
        .result    (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            invalid  <= 1'b0;
            dst_idx  <= '0;
            wr_data  <= '0;
            insn_len <= '0;
        end else begin
            done    <= fin_ok | fin_bad;
            invalid <= fin_bad;
            if (fin_ok) begin
                wr_data <= result;
                dst_idx <= ctl.dst;
            end
            if (fin_ok | fin_bad)
                insn_len <= len;
        end
    end

endmodule

// File: rtl/lea_unit_chk.sv
module lea_unit_chk #(
    parameter int LEN_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              invalid,
    input logic [3:0]        dst_idx,
    input logic [63:0]       wr_data,
    input logic [LEN_W-1:0]  insn_len
);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_outputs_r12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(wr_data) && $stable(dst_idx) && $stable(insn_len)));

    p_invalid_with_done_r11: assert property (@(posedge clk) disable iff (rst)
        invalid |-> done);

    p_invalid_keeps_data_r11: assert property (@(posedge clk) disable iff (rst)
        invalid |-> ($stable(wr_data) && $stable(dst_idx)));

    p_min_len_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !invalid) |-> (insn_len >= LEN_W'(2)));

endmodule

bind lea_unit lea_unit_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .invalid  (invalid),
    .dst_idx  (dst_idx),
    .wr_data  (wr_data),
    .insn_len (insn_len)
);

// File: tb/lea_unit_bench.sv
module lea_unit_bench;

    localparam int NB = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NB*8-1:0] insn_bytes = '0;
    logic [63:0]   insn_addr = '0;
    logic [3:0]    rf_raddr;
    logic [63:0]   rf_rdata;
    logic          done, invalid;
    logic [3:0]    dst_idx;
    logic [63:0]   wr_data;
    logic [3:0]    insn_len;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    function automatic logic [63:0] regval(logic [3:0] i);
        return (64'h9E37_79B9_7F4A_7C15 * (64'(i) + 64'd1)) ^ (64'h00F0_0000_0000_00F0 << i);
    endfunction

    assign rf_rdata = regval(rf_raddr);

    lea_unit u_lea_unit (
        .clk(clk), .rst(rst), .start(start), .insn_bytes(insn_bytes),
        .insn_addr(insn_addr), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .done(done), .invalid(invalid), .dst_idx(dst_idx),
        .wr_data(wr_data), .insn_len(insn_len)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic next_seed();
        seed = seed * 32'd1103515245 + 32'd12345;
    endtask

    // Pulse start and wait for done; returns 1 if done seen.
    task automatic launch(output bit seen);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic run_case(bit w, bit p66, bit p67, bit swap,
                            logic [3:0] dst, logic [1:0] md, logic [3:0] rm,
                            logic [1:0] scale, logic [3:0] idx, logic [3:0] base,
                            logic [31:0] disp, logic [63:0] addr);
        logic [7:0] b [NB];
        int n = 0;
        bit sib = (rm[2:0] == 3'd4);
        logic [3:0] bsel = sib ? base : rm;
        logic [3:0] xsel = sib ? idx : 4'd0;
        int need;
        bit rip, use_b, use_x;
        logic [63:0] ea, exp, dext;
        string tag;
        bit seen;
        for (int k = 0; k < NB; k++) b[k] = 8'h90;
        if (p66 && p67) begin
            b[n] = swap ? 8'h67 : 8'h66; n++;
            b[n] = swap ? 8'h66 : 8'h67; n++;
        end else if (p66) begin b[n] = 8'h66; n++; end
        else if (p67) begin b[n] = 8'h67; n++; end
        if (w || dst[3] || xsel[3] || bsel[3]) begin
            b[n] = {4'h4, w, dst[3], xsel[3], bsel[3]}; n++;
        end
        b[n] = 8'h8D; n++;
        b[n] = {md, dst[2:0], rm[2:0]}; n++;
        if (sib) begin b[n] = {scale, idx[2:0], base[2:0]}; n++; end
        need = (md == 2'd1) ? 1 : (md == 2'd2) ? 4 :
               ((md == 2'd0) && (bsel[2:0] == 3'd5)) ? 4 : 0;
        for (int k = 0; k < need; k++) begin b[n] = disp[8*k +: 8]; n++; end
        rip   = !sib && md == 2'd0 && rm[2:0] == 3'd5;
        use_b = !rip && !(sib && md == 2'd0 && base[2:0] == 3'd5);
        use_x = sib && idx != 4'd4;
        dext  = (need == 1) ? {{56{disp[7]}}, disp[7:0]} :
                (need == 4) ? {{32{disp[31]}}, disp} : 64'd0;
        ea = (rip ? addr + 64'(n) : (use_b ? regval(bsel) : 64'd0))
             + (use_x ? (regval(idx) << scale) : 64'd0) + dext;
        if (p67) ea[63:32] = 32'd0;
        if (w)        exp = ea;
        else if (p66) exp = {regval(dst)[63:16], ea[15:0]};
        else          exp = {32'd0, ea[31:0]};
        if (rip)                            tag = "R8 rip-relative";
        else if (sib && !use_b)             tag = "R7 no-base";
        else if (sib)                       tag = "R6 sib";
        else if (p66 && !w)                 tag = (p67 ? "R9 both prefixes" : "R3 16-bit merge");
        else if (p67)                       tag = "R4 addr32";
        else if (w)                         tag = "R1 64-bit";
        else                                tag = "R2 32-bit";
        for (int k = 0; k < NB; k++) insn_bytes[8*k +: 8] = b[k];
        insn_addr = addr;
        launch(seen);
        if (!seen) begin
            check64("R12 done missing", 64'd0, 64'd1);
        end else begin
            check64(tag, wr_data, exp);
            check64("R10 length", 64'(insn_len), 64'(n));
            check64("R5 dst/valid", {59'd0, invalid, dst_idx}, {59'd0, 1'b0, dst});
            @(negedge clk);
            check64("R12 done single", 64'(done), 64'd0);
        end
    endtask

    task automatic run_bad(logic [119:0] bytes, string tag);
        logic [63:0] prev_d = wr_data;
        logic [3:0]  prev_i = dst_idx;
        bit seen;
        insn_bytes = bytes;
        launch(seen);
        check64({tag, " invalid"}, {62'd0, seen, invalid}, 64'd3);
        check64({tag, " no write"}, wr_data, prev_d);
        check64({tag, " dst held"}, 64'(dst_idx), 64'(prev_i));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check64("R12 reset outputs", {wr_data[31:0], 22'd0, done, invalid, dst_idx, insn_len},
                64'd0);
        rst = 1'b0;
        @(negedge clk);

        // ModRM sweep: every mod, destination, rm and size/prefix combination.
        for (int md = 0; md < 3; md++)
            for (int d = 0; d < 16; d++)
                for (int r = 0; r < 16; r++) begin
                    if (r[2:0] == 3'd4) continue;
                    for (int sz = 0; sz < 8; sz++) begin
                        next_seed();
                        run_case(sz[0], sz[1], sz[2], d[0] ^ r[0], 4'(d), 2'(md), 4'(r),
                                 2'd0, 4'd0, 4'd0, seed, {seed, ~seed});
                    end
                end

        // SIB sweep: every mod, base, index and scale.
        for (int md = 0; md < 3; md++)
            for (int bs = 0; bs < 16; bs++)
                for (int ix = 0; ix < 16; ix++)
                    for (int sc = 0; sc < 4; sc++) begin
                        next_seed();
                        run_case(seed[3], seed[5], seed[7], seed[9], 4'(seed[14:11]),
                                 2'(md), {seed[16], 3'd4}, 2'(sc), 4'(ix), 4'(bs),
                                 seed, 64'h0);
                    end

        // RIP-relative with address wrap and negative displacement (R8, R4).
        run_case(1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 2'd0, 4'd5, 2'd0, 4'd0, 4'd0,
                 32'hFFFF_FF00, 64'hFFFF_FFFF_FFFF_FFF0);
        run_case(1'b1, 1'b0, 1'b1, 1'b0, 4'd9, 2'd0, 4'd13, 2'd0, 4'd0, 4'd0,
                 32'h0000_0040, 64'h0000_0001_FFFF_FFF8);

        // Rejected encodings (R11): mod 3, and wrong opcodes after prefixes.
        run_bad({96'h9090_9090_9090_9090_9090_9090, 24'hC18D48}, "R11 mod3");
        run_bad({96'h9090_9090_9090_9090_9090_9090, 24'h008B48}, "R11 opcode");
        run_bad({96'h9090_9090_9090_9090_9090_9090, 24'h0F6766}, "R11 prefixed opcode");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule